// File: doc/BRIEF.md
# Configurable External Interrupt Pin Capture

This block watches a bank of asynchronous interrupt pins and turns the activity it is configured to look for into one pending flag per pin. Each pin has four configuration bits of its own: an enable, a detection-style select (level or edge), a polarity select, and a both-edges select. Pin inputs are brought into the clock domain by a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier.

A pending flag is set whenever an enabled pin meets its trigger condition. It stays set until one of two things happens. Either the interrupt arbiter downstream acknowledges service of that pin by its index, or software writes 0 to that flag bit through the register port. When the both-edges select is 1, every transition triggers, and the level/edge select and the polarity select have no effect for that pin. A pin in level mode keeps re-raising its flag for as long as the active level is present.

Top module: `pin_irq_capture`

## Requirements
- R1: A pin change that has settled before a rising clock edge is seen by the flag on the third rising edge from that point, and not on the first or second.
- R2: A flag is set only while the pin's bit in the enable register (address 0) is 1. With the bit at 0, trigger activity leaves the flag at 0.
- R3: When `ack_valid` is 1, the flag selected by `ack_idx` is cleared on that clock edge.
- R4: A write to the flag register (address 4) clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged.
- R5: Edge mode is selected when the mode bit (address 1) is 1. With the polarity bit (address 2) at 0, a rising edge triggers. With it at 1, a falling edge triggers.
- R6: Level mode is selected when the mode bit is 0. The pin triggers while it is high (polarity 0) or low (polarity 1), on every cycle the level lasts, so a flag is raised again right after it has been cleared.
- R7: When the both-edges bit (address 3) is 1, rising and falling edges both trigger, a steady pin never triggers, and the mode and polarity bits are ignored.
- R8: If a pin triggers in the same cycle as an acknowledge or a write-0 clear of its flag, the flag is 1 afterwards.
- R9: After synchronous reset, all flags and all configuration registers are 0. Polarity 0 means high level or rising edge.
- R10: The register at `rd_addr` (0 enable, 1 mode, 2 polarity, 3 both-edges, 4 flags, any other address reads 0) appears on `rd_data` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NPINS | Register write data, one bit per pin |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NPINS | Registered read data |
| ack_valid | input | 1 | Service acknowledge from the arbiter |
| ack_idx | input | IDX_W | Index of the pin being acknowledged |
| irq_flag | output | NPINS | Pending flags toward the arbiter |

## Verification
The bench builds the block with its default values: eight pins and a two-stage synchroniser. With eight pins, a single table row can give every pin its own combination of mode, polarity, both-edges and enable setting, so the modes are checked against each other under one shared stimulus. The two-stage depth fixes the three-edge latency that the directed tests measure. The directed tests also cover acknowledge by index, write-0 clearing, the set-over-clear collision, level re-raise and register read-back.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  typedef enum logic [2:0] {
    REG_ENABLE   = 3'd0,
    REG_MODE     = 3'd1,
    REG_POLARITY = 3'd2,
    REG_BOTH     = 3'd3,
    REG_FLAGS    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= stage[STAGES-1];
  end

  assign cur = stage[STAGES-1];
endmodule

// File: rtl/extirq_trigger.sv
module extirq_trigger #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol_low,
  input  logic [W-1:0] both,
  output logic [W-1:0] hit
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    always_comb begin
      if (both[g])          hit[g] = cur[g] ^ prev[g];
      else if (edge_sel[g]) hit[g] = pol_low[g] ? (prev[g] & ~cur[g]) : (cur[g] & ~prev[g]);
      else                  hit[g] = pol_low[g] ? ~cur[g] : cur[g];
    end
  end
endmodule

// File: rtl/extirq_flags.sv
module extirq_flags #(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     set_vec,
  input  logic [W-1:0]     sw_clr,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [W-1:0]     flag
);
  logic [W-1:0] ack_clr;

  always_comb begin
    ack_clr = '0;
    if (ack_valid) ack_clr[ack_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= '0;
    else     flag <= (flag & ~(ack_clr | sw_clr)) | set_vec;
  end
endmodule

// File: rtl/pin_irq_capture.sv
module pin_irq_capture #(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [NPINS-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [NPINS-1:0] rd_data,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [NPINS-1:0] irq_flag
);
  import extirq_pkg::*;

  logic [NPINS-1:0] en_q, mode_q, pol_q, both_q;
  logic [NPINS-1:0] sync_cur, sync_prev, hit, set_vec, sw_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_ENABLE:   en_q   <= wr_data;
        REG_MODE:     mode_q <= wr_data;
        REG_POLARITY: pol_q  <= wr_data;
        REG_BOTH:     both_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign sw_clr  = (wr_en && wr_addr == REG_FLAGS) ? ~wr_data : '0;
  assign set_vec = hit & en_q;

  extirq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_i), .cur(sync_cur), .prev(sync_prev)
  );

  extirq_trigger #(.W(NPINS)) u_trig (
    .cur(sync_cur), .prev(sync_prev), .edge_sel(mode_q),
    .pol_low(pol_q), .both(both_q), .hit(hit)
  );

  extirq_flags #(.W(NPINS), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .sw_clr(sw_clr),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .flag(irq_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        REG_ENABLE:   rd_data <= en_q;
        REG_MODE:     rd_data <= mode_q;
        REG_POLARITY: rd_data <= pol_q;
        REG_BOTH:     rd_data <= both_q;
        REG_FLAGS:    rd_data <= irq_flag;
        default:      rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/extirq_checker.sv
module extirq_checker #(
  parameter int NPINS = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] flag,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] pol,
  input logic [NPINS-1:0] both,
  input logic [NPINS-1:0] set_vec,
  input logic [NPINS-1:0] cur,
  input logic [NPINS-1:0] prev,
  input logic             ack_valid,
  input logic [IDX_W-1:0] ack_idx,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [NPINS-1:0] wr_data
);
  p_set_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
    ((flag & ~$past(flag) & ~$past(en)) == '0));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> (flag[$past(ack_idx)] == $past(set_vec[ack_idx])));

  p_write_one_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd4 && !ack_valid) |=>
      (((flag ^ ($past(flag) | $past(set_vec))) & $past(wr_data)) == '0));

  p_both_needs_change_r7: assert property (@(posedge clk) disable iff (rst)
    ((set_vec & both & ~(cur ^ prev)) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> (($past(set_vec) & ~flag) == '0));

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (flag == '0 && en == '0 && pol == '0 && both == '0));
endmodule

bind pin_irq_capture extirq_checker #(.NPINS(NPINS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .flag(irq_flag), .en(en_q), .pol(pol_q), .both(both_q),
  .set_vec(set_vec), .cur(sync_cur), .prev(sync_prev),
  .ack_valid(ack_valid), .ack_idx(ack_idx),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/pin_irq_capture_bench.sv
module pin_irq_capture_bench;
  localparam int NPINS = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NPINS-1:0] pin_i = '0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [NPINS-1:0] wr_data = '0;
  logic [2:0]       rd_addr = '0;
  logic [NPINS-1:0] rd_data;
  logic             ack_valid = 1'b0;
  logic [IDX_W-1:0] ack_idx = '0;
  logic [NPINS-1:0] irq_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_irq_capture u_pin_irq_capture (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .irq_flag(irq_flag)
  );

  // Row fields: enable, mode(1=edge), polarity(1=low/falling), both, pins before, pins after, expected flags
  localparam int NROWS = 6;
  localparam logic [55:0] VEC [NROWS] = '{
    {8'hFF, 8'h0F, 8'hAA, 8'h00, 8'h00, 8'hFF, 8'hF5},
    {8'hFF, 8'h0F, 8'hAA, 8'h00, 8'hFF, 8'h00, 8'hFA},
    {8'hFF, 8'h0F, 8'hAA, 8'h00, 8'h00, 8'h00, 8'hA0},
    {8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h3C, 8'h33},
    {8'h0F, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h0F},
    {8'hFF, 8'hFF, 8'hFF, 8'h0F, 8'h55, 8'hAA, 8'h5F}
  };

  task automatic check(input string req, input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NPINS-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [NPINS-1:0] exp);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 flags", irq_flag, 8'h00);
    rd_check("R9 polarity", 3'd2, 8'h00);
    rd_check("R9 enable", 3'd0, 8'h00);

    // Vector table: modes side by side (R5 R6 R7 R2)
    for (int r = 0; r < NROWS; r++) begin
      wr(3'd0, VEC[r][55:48]);
      wr(3'd1, VEC[r][47:40]);
      wr(3'd2, VEC[r][39:32]);
      wr(3'd3, VEC[r][31:24]);
      pin_i = VEC[r][23:16];
      wait_n(4);
      wr(3'd4, 8'h00);
      pin_i = VEC[r][15:8];
      wait_n(4);
      check($sformatf("R5 R6 R7 R2 row%0d", r), irq_flag, VEC[r][7:0]);
    end

    // R1: latency, edge mode rising on pin 2
    wr(3'd0, 8'h04); wr(3'd1, 8'hFF); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    pin_i = 8'h00; wait_n(4); wr(3'd4, 8'h00);
    @(negedge clk); pin_i = 8'h04;
    wait_n(2);
    check("R1 not yet", irq_flag, 8'h00);
    wait_n(1);
    check("R1 third edge", irq_flag, 8'h04);

    // R10: read back flags and config; unused address
    rd_check("R10 flags", 3'd4, 8'h04);
    rd_check("R10 mode", 3'd1, 8'hFF);
    rd_check("R10 unused", 3'd6, 8'h00);

    // R3: acknowledge clears indexed flag
    @(negedge clk); ack_valid = 1'b1; ack_idx = 3'd2;
    @(negedge clk); ack_valid = 1'b0;
    check("R3 ack", irq_flag, 8'h00);

    // R4: write 1 keeps, write 0 clears
    wr(3'd0, 8'h03); pin_i = 8'h07; wait_n(4);
    check("R4 setup", irq_flag, 8'h03);
    wr(3'd4, 8'h02);
    check("R4 keep1 clear0", irq_flag, 8'h02);

    // R6: level mode re-raises right after clear
    wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd4, 8'h00);
    pin_i = 8'h01; wait_n(4);
    check("R6 level set", irq_flag, 8'h01);
    wr(3'd4, 8'h00);
    check("R6 re-raise", irq_flag, 8'h01);

    // R8: set wins over acknowledge
    @(negedge clk); ack_valid = 1'b1; ack_idx = 3'd0;
    @(negedge clk); ack_valid = 1'b0;
    check("R8 set wins", irq_flag, 8'h01);

    // R2: disabling stops new flags
    wr(3'd0, 8'h00); wr(3'd4, 8'h00);
    wait_n(2);
    check("R2 disabled", irq_flag, 8'h00);
    rd_check("R2 enable readback", 3'd0, 8'h00);

    // R9: reset again clears configuration
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 flags after reset", irq_flag, 8'h00);
    rd_check("R9 mode after reset", 3'd1, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule